// File: doc/BRIEF.md
# Packet Framing Error Enforcer

This block sits in line on a multi-port packet stream. Each beat carries an enable, a port index, start and end markers, an error flag and a data word. For every port the block remembers whether a packet is open. A start marker that arrives while that port's packet is still open means the closing end marker was lost. When that happens the block closes the broken packet on its output with a synthesized end beat flagged as an error, and it raises a one-cycle missing-end pulse.

After a missing-end event the block enters a discard state for that port. It swallows every beat for that port until an end marker arrives on the input. The beat after that is treated as the start of clean traffic. Other ports are not affected.

All outputs are registered, so each accepted beat appears on the output exactly one clock after it was presented. The block has no back-pressure and no buffering. Downstream logic must accept one beat per cycle.

Top module: `pfg_frame_guard`

## Requirements
- R1: A beat that is forwarded appears on the outputs one clock after its input cycle, with out_en high and port index, start, end and data equal to the input. The error flag equals the input unless R7 applies.
- R2: A beat with in_en and in_sop high on a port whose packet is open causes missing_eop to be high for exactly one cycle, one clock later, with missing_eop_port equal to that port.
- R3: In the cycle missing_eop is high, the output carries a forced closing beat: out_en=1, out_sop=0, out_eop=1, out_err=1, out_data=0, out_port equal to the offending port.
- R4: The offending start beat is not forwarded. Every later beat on that port, up to and including the input end beat that ends the discard state, produces no output (out_en=0 one clock later).
- R5: The first start beat on a port after its discard state has ended is forwarded as a normal packet start, with no missing_eop.
- R6: A beat with both start and end high on a port with an open packet triggers R2 and R3. Its own end marker closes the event, so the port is idle and not discarding afterwards.
- R7: An end beat without start, on a port that is idle and not discarding, is forwarded with out_err forced to 1.
- R8: A beat with both start and end high on an idle port is forwarded unchanged as a one-beat packet and leaves the port idle. A following start beat raises no missing_eop.
- R9: Open and discard state is kept per port. Beats on other ports are forwarded normally while one port is discarding.
- R10: A synchronous reset (rst high) clears all per-port state. During reset and in the cycle after, out_en and missing_eop are 0. A start beat after reset on a port that was open before is a normal start.
- R11: A cycle with in_en low produces out_en=0 one clock later and changes no port state.
- R12: An end beat on a port with an open packet is forwarded unchanged, including its input error flag, and closes the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_en | input | 1 | Input beat valid |
| in_port | input | PORT_W | Port index of the input beat |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| in_err | input | 1 | Input error flag |
| in_data | input | DATA_W | Input data word |
| out_en | output | 1 | Output beat valid |
| out_port | output | PORT_W | Port index of the output beat |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_err | output | 1 | Output error flag |
| out_data | output | DATA_W | Output data word (zero on forced beats) |
| missing_eop | output | 1 | One-cycle pulse on a missing-end event |
| missing_eop_port | output | PORT_W | Port of the last missing-end event |

## Verification
The assertions assume that in_port always names an existing port and that no input is unknown in a cycle where in_en is high. The checks on forced beats and on output-to-input correspondence hold only under those assumptions. The stimulus draws port indices only below the port count and drives every input to a known value in every cycle, including cycles where in_en is low. Reset is asserted from time zero and once more in the middle of the run, while a packet is open.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

   // Decision taken for one input beat
   typedef enum logic [2:0] {
      ACT_NONE      = 3'd0,  // no beat this cycle
      ACT_PASS      = 3'd1,  // forward unchanged
      ACT_MARK_ERR  = 3'd2,  // forward with error forced high
      ACT_FORCE_EOP = 3'd3,  // emit synthesized closing beat
      ACT_DISCARD   = 3'd4   // swallow the beat
   } pfg_act_e;

   // Per-port framing state
   typedef struct packed {
      logic open;   // packet in progress
      logic drop;   // discarding until an input end marker
   } pfg_flags_t;

endpackage

// File: rtl/pfg_port_state.sv
module pfg_port_state #(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [PORT_W-1:0]   wr_port,
   input  pfg_pkg::pfg_flags_t wr_flags,
   input  logic [PORT_W-1:0]   rd_port,
   output pfg_pkg::pfg_flags_t rd_flags
);
   import pfg_pkg::*;

   generate
      if (NUM_PORTS == 1) begin : g_single
         pfg_flags_t flags_q;
         logic       unused_idx;

         always_ff @(posedge clk) begin
            if (rst)        flags_q <= '0;
            else if (wr_en) flags_q <= wr_flags;
         end

         assign rd_flags   = flags_q;
         assign unused_idx = ^{wr_port, rd_port};
      end else begin : g_multi
         pfg_flags_t flags_q [NUM_PORTS];

         always_ff @(posedge clk) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
               if (rst)
                  flags_q[i] <= '0;
               else if (wr_en && (wr_port == PORT_W'(i)))
                  flags_q[i] <= wr_flags;
            end
         end

         always_comb begin
            rd_flags = '0;
            for (int i = 0; i < NUM_PORTS; i++) begin
               if (rd_port == PORT_W'(i)) rd_flags = flags_q[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pfg_classify.sv
module pfg_classify (
   input  logic                in_en,
   input  logic                in_sop,
   input  logic                in_eop,
   input  pfg_pkg::pfg_flags_t cur,
   output pfg_pkg::pfg_act_e   act,
   output pfg_pkg::pfg_flags_t nxt,
   output logic                upd
);
   import pfg_pkg::*;

   always_comb begin
      act = ACT_NONE;
      nxt = cur;
      upd = 1'b0;
      if (in_en) begin
         upd = 1'b1;
         if (cur.drop) begin
            // swallow everything; a real end marker resumes normal traffic
            act = ACT_DISCARD;
            if (in_eop) nxt.drop = 1'b0;
         end else if (cur.open) begin
            if (in_sop) begin
               // lost end marker: close the packet, then discard
               act      = ACT_FORCE_EOP;
               nxt.open = 1'b0;
               nxt.drop = ~in_eop;
            end else begin
               act = ACT_PASS;
               if (in_eop) nxt.open = 1'b0;
            end
         end else begin
            if (in_sop) begin
               act      = ACT_PASS;
               nxt.open = ~in_eop;
            end else if (in_eop) begin
               act = ACT_MARK_ERR;
            end else begin
               act = ACT_PASS;
            end
         end
      end
   end

endmodule

// File: rtl/pfg_out_stage.sv
module pfg_out_stage #(
   parameter int DATA_W = 32,
   parameter int PORT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  pfg_pkg::pfg_act_e act,
   input  logic [PORT_W-1:0] in_port,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic              in_err,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_en,
   output logic [PORT_W-1:0] out_port,
   output logic              out_sop,
   output logic              out_eop,
   output logic              out_err,
   output logic [DATA_W-1:0] out_data,
   output logic              missing_eop,
   output logic [PORT_W-1:0] missing_eop_port
);
   import pfg_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_en           <= 1'b0;
         out_port         <= '0;
         out_sop          <= 1'b0;
         out_eop          <= 1'b0;
         out_err          <= 1'b0;
         out_data         <= '0;
         missing_eop      <= 1'b0;
         missing_eop_port <= '0;
      end else begin
         out_en      <= 1'b0;
         out_sop     <= 1'b0;
         out_eop     <= 1'b0;
         out_err     <= 1'b0;
         out_data    <= '0;
         missing_eop <= 1'b0;
         case (act)
            ACT_PASS, ACT_MARK_ERR: begin
               out_en   <= 1'b1;
               out_port <= in_port;
               out_sop  <= in_sop;
               out_eop  <= in_eop;
               out_err  <= in_err | (act == ACT_MARK_ERR);
               out_data <= in_data;
            end
            ACT_FORCE_EOP: begin
               out_en           <= 1'b1;
               out_port         <= in_port;
               out_eop          <= 1'b1;
               out_err          <= 1'b1;
               missing_eop      <= 1'b1;
               missing_eop_port <= in_port;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pfg_frame_guard.sv
module pfg_frame_guard #(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 32
) (
   input  logic                                             clk,
   input  logic                                             rst,
   input  logic                                             in_en,
   input  logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] in_port,
   input  logic                                             in_sop,
   input  logic                                             in_eop,
   input  logic                                             in_err,
   input  logic [DATA_W-1:0]                                in_data,
   output logic                                             out_en,
   output logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] out_port,
   output logic                                             out_sop,
   output logic                                             out_eop,
   output logic                                             out_err,
   output logic [DATA_W-1:0]                                out_data,
   output logic                                             missing_eop,
   output logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] missing_eop_port
);
   import pfg_pkg::*;

   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("pfg_frame_guard: NUM_PORTS must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("pfg_frame_guard: DATA_W must be at least 1");
      end
   endgenerate

   pfg_flags_t cur_flags;
   pfg_flags_t nxt_flags;
   pfg_act_e   act;
   logic       upd;

   pfg_port_state #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
   ) u_state (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (upd),
      .wr_port  (in_port),
      .wr_flags (nxt_flags),
      .rd_port  (in_port),
      .rd_flags (cur_flags)
   );

   pfg_classify u_classify (
      .in_en  (in_en),
      .in_sop (in_sop),
      .in_eop (in_eop),
      .cur    (cur_flags),
      .act    (act),
      .nxt    (nxt_flags),
      .upd    (upd)
   );

   pfg_out_stage #(
      .DATA_W (DATA_W),
      .PORT_W (PORT_W)
   ) u_out (
      .clk              (clk),
      .rst              (rst),
      .act              (act),
      .in_port          (in_port),
      .in_sop           (in_sop),
      .in_eop           (in_eop),
      .in_err           (in_err),
      .in_data          (in_data),
      .out_en           (out_en),
      .out_port         (out_port),
      .out_sop          (out_sop),
      .out_eop          (out_eop),
      .out_err          (out_err),
      .out_data         (out_data),
      .missing_eop      (missing_eop),
      .missing_eop_port (missing_eop_port)
   );

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
   parameter int DATA_W = 32,
   parameter int PORT_W = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              in_en,
   input logic [PORT_W-1:0] in_port,
   input logic              in_sop,
   input logic [DATA_W-1:0] in_data,
   input logic              out_en,
   input logic [PORT_W-1:0] out_port,
   input logic              out_sop,
   input logic              out_eop,
   input logic              out_err,
   input logic [DATA_W-1:0] out_data,
   input logic              missing_eop,
   input logic [PORT_W-1:0] missing_eop_port
);

   // R3: the pulse always coincides with a well-formed closing beat
   a_r3_forced_beat: assert property (@(posedge clk) disable iff (rst)
      missing_eop |-> (out_en && out_eop && out_err && !out_sop &&
                       out_data == '0 && out_port == missing_eop_port));

   // R2: a pulse is caused by a start beat on the same port one clock before
   a_r2_pulse_cause: assert property (@(posedge clk) disable iff (rst)
      missing_eop |-> ($past(in_en) && $past(in_sop) &&
                       $past(in_port) == missing_eop_port));

   // R11: no output beat without an input beat one clock before
   a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
      out_en |-> $past(in_en));

   // R1: a forwarded beat keeps its port and data
   a_r1_passthrough: assert property (@(posedge clk) disable iff (rst)
      (out_en && !missing_eop) |-> (out_port == $past(in_port) &&
                                    out_data == $past(in_data)));

   // R10: outputs are quiet in the cycle after a reset cycle
   a_r10_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> (!out_en && !missing_eop));

endmodule

bind pfg_frame_guard pfg_checker #(
   .DATA_W (DATA_W),
   .PORT_W (PORT_W)
) u_chk (
   .clk              (clk),
   .rst              (rst),
   .in_en            (in_en),
   .in_port          (in_port),
   .in_sop           (in_sop),
   .in_data          (in_data),
   .out_en           (out_en),
   .out_port         (out_port),
   .out_sop          (out_sop),
   .out_eop          (out_eop),
   .out_err          (out_err),
   .out_data         (out_data),
   .missing_eop      (missing_eop),
   .missing_eop_port (missing_eop_port)
);

// File: tb/test_pfg_frame_guard.sv
`timescale 1ns/1ps
module test_pfg_frame_guard;

   localparam int NP = 4;
   localparam int DW = 32;
   localparam int PW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_en = 1'b0;
   logic [PW-1:0] in_port = '0;
   logic          in_sop = 1'b0;
   logic          in_eop = 1'b0;
   logic          in_err = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_en;
   logic [PW-1:0] out_port;
   logic          out_sop;
   logic          out_eop;
   logic          out_err;
   logic [DW-1:0] out_data;
   logic          missing_eop;
   logic [PW-1:0] missing_eop_port;

   always #10 clk = ~clk;

   pfg_frame_guard #(.NUM_PORTS(NP), .DATA_W(DW)) i_pfg_frame_guard (
      .clk(clk), .rst(rst), .in_en(in_en), .in_port(in_port),
      .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err), .in_data(in_data),
      .out_en(out_en), .out_port(out_port), .out_sop(out_sop),
      .out_eop(out_eop), .out_err(out_err), .out_data(out_data),
      .missing_eop(missing_eop), .missing_eop_port(missing_eop_port)
   );

   typedef struct packed {
      logic          vld;
      logic [PW-1:0] port;
      logic          sop;
      logic          eop;
      logic          err;
      logic [DW-1:0] data;
      logic          meop;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   exp_t  cur_exp;
   string cur_tag;
   bit    have_exp = 1'b0;
   int    checks = 0;
   int    fails  = 0;
   bit    m_open [NP];
   bit    m_drop [NP];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // Driver: present one beat and predict the output from the requirements
   task automatic beat(input bit en, input int p, input bit s, input bit e,
                       input bit er, input logic [DW-1:0] d, input string tag);
      exp_t x;
      @(negedge clk);
      in_en = en; in_port = PW'(p); in_sop = s; in_eop = e; in_err = er; in_data = d;
      x = '0;
      if (en) begin
         if (m_drop[p]) begin                       // R4
            if (e) m_drop[p] = 1'b0;
         end else if (m_open[p]) begin
            if (s) begin                            // R2 R3 R6
               x.vld = 1; x.port = PW'(p); x.eop = 1; x.err = 1; x.meop = 1;
               m_open[p] = 1'b0;
               m_drop[p] = !e;
            end else begin                          // R1 R12
               x.vld = 1; x.port = PW'(p); x.eop = e; x.err = er; x.data = d;
               if (e) m_open[p] = 1'b0;
            end
         end else begin
            x.vld = 1; x.port = PW'(p); x.sop = s; x.eop = e; x.data = d;
            x.err = er | (e & !s);                  // R7
            if (s) m_open[p] = !e;                  // R8
         end
      end
      exp_q.push_back(x);
      tag_q.push_back(tag);
   endtask

   task automatic reset_cycle(input string tag);
      exp_t x;
      @(negedge clk);
      rst = 1'b1; in_en = 1'b1; in_port = '0; in_sop = 1'b1; in_eop = 1'b0;
      x = '0;
      exp_q.push_back(x);
      tag_q.push_back(tag);
      for (int i = 0; i < NP; i++) begin m_open[i] = 0; m_drop[i] = 0; end
      @(negedge clk);
      rst = 1'b0; in_en = 1'b0; in_sop = 1'b0;
      exp_q.push_back(x);
      tag_q.push_back(tag);
   endtask

   // Monitor: pop the prediction at the edge that registers it, compare after
   always @(posedge clk) begin
      if (exp_q.size() > 0) begin
         cur_exp  <= exp_q.pop_front();
         cur_tag  <= tag_q.pop_front();
         have_exp <= 1'b1;
      end else begin
         have_exp <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (have_exp) begin
         if (cur_exp.vld) begin
            check(out_en && out_port == cur_exp.port && out_sop == cur_exp.sop &&
                  out_eop == cur_exp.eop && out_err == cur_exp.err &&
                  out_data == cur_exp.data && missing_eop == cur_exp.meop &&
                  (!cur_exp.meop || missing_eop_port == cur_exp.port),
                  cur_tag, "beat {en,port,sop,eop,err,meop,data}",
                  {out_en, 2'(out_port), out_sop, out_eop, out_err, missing_eop, out_data},
                  {1'b1, 2'(cur_exp.port), cur_exp.sop, cur_exp.eop, cur_exp.err,
                   cur_exp.meop, cur_exp.data});
         end else begin
            check(!out_en && !missing_eop, cur_tag, "idle {en,meop}",
                  {out_en, missing_eop}, 0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NP; i++) begin m_open[i] = 0; m_drop[i] = 0; end
      repeat (3) @(negedge clk);
      check(!out_en && !missing_eop, "R10", "reset outputs", {out_en, missing_eop}, 0);
      @(negedge clk);
      rst = 1'b0;

      // R11: disabled cycle with strobes high does nothing
      beat(0, 0, 1, 0, 0, 32'hdead0001, "R11");
      beat(1, 0, 0, 1, 0, 32'h00000002, "R11 stray eop after disabled sop");
      // R1 R12: normal packet with error on its end
      beat(1, 0, 1, 0, 0, 32'h10000001, "R1");
      beat(1, 0, 0, 0, 0, 32'h10000002, "R1");
      beat(1, 0, 0, 1, 1, 32'h10000003, "R12");
      // R2 R3 R4 R5
      beat(1, 1, 1, 0, 0, 32'h20000001, "R1");
      beat(1, 1, 0, 0, 0, 32'h20000002, "R1");
      beat(1, 1, 1, 0, 0, 32'h20000003, "R2 R3");
      beat(1, 1, 0, 0, 0, 32'h20000004, "R4");
      beat(1, 1, 1, 0, 0, 32'h20000005, "R4 sop while dropping");
      beat(1, 1, 0, 1, 0, 32'h20000006, "R4 clearing eop");
      beat(1, 1, 1, 0, 0, 32'h20000007, "R5");
      beat(1, 1, 0, 1, 0, 32'h20000008, "R5");
      // R9: port 2 keeps flowing while port 3 drops
      beat(1, 2, 1, 0, 0, 32'h30000001, "R9");
      beat(1, 3, 1, 0, 0, 32'h30000002, "R9");
      beat(1, 3, 1, 0, 0, 32'h30000003, "R9 R2");
      beat(1, 2, 0, 0, 0, 32'h30000004, "R9");
      beat(1, 3, 0, 0, 0, 32'h30000005, "R9 R4");
      beat(1, 2, 0, 1, 0, 32'h30000006, "R9");
      beat(1, 3, 0, 1, 0, 32'h30000007, "R9 R4");
      // R7: stray end on idle port
      beat(1, 0, 0, 1, 0, 32'h40000001, "R7");
      // R8: single-beat packet then normal start
      beat(1, 0, 1, 1, 0, 32'h50000001, "R8");
      beat(1, 0, 1, 0, 0, 32'h50000002, "R8 following sop");
      beat(1, 0, 0, 1, 0, 32'h50000003, "R8");
      // R6: sop+eop on open port closes the event
      beat(1, 1, 1, 0, 0, 32'h60000001, "R6");
      beat(1, 1, 1, 1, 0, 32'h60000002, "R6 forced");
      beat(1, 1, 0, 0, 0, 32'h60000003, "R6 not dropping");
      beat(1, 1, 1, 0, 0, 32'h60000004, "R6 clean start");
      beat(1, 1, 0, 1, 0, 32'h60000005, "R6");
      // R10: reset with a packet open
      beat(1, 2, 1, 0, 0, 32'h70000001, "R10");
      reset_cycle("R10");
      beat(1, 2, 1, 0, 0, 32'h70000002, "R10 start after reset");
      beat(1, 2, 0, 1, 0, 32'h70000003, "R10");
      // R9: mixed traffic
      for (int n = 0; n < 400; n++) begin
         int p;
         p = int'($urandom_range(NP - 1, 0));
         beat($urandom_range(9, 0) < 8, p, $urandom_range(3, 0) == 0,
              $urandom_range(3, 0) == 0, $urandom_range(9, 0) == 0,
              $urandom, "R9 mixed");
      end
      repeat (3) beat(0, 0, 0, 0, 0, '0, "R11 drain");
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule